// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block sits between an internal queue of external-bus access requests and a static-memory bus controller. Before each access starts, it decides whether one idle cycle must be placed in front of it, and which kind of idle cycle. Three kinds exist:

- **Chip-select change:** the access goes to a different device than the previous access.
- **Configuration reload:** software rewrote a device's mode configuration.
- **Early read:** a read with a nonzero setup phase follows a write that the write strobe controls and that has no hold phase.

When several conditions apply at once, they merge into a single idle cycle chosen by a fixed priority.

The sequencer records three things: the chip select of the last accepted access, whether that access was a write with no hold phase controlled by the write strobe, and a pending-reload flag. The flag is raised by a write to the mode register of any chip select. Writes to the setup, pulse and cycle timing registers do not raise it. The register file, the timing counters and the pin drivers are outside the block. They are represented only by the configuration-write inputs and by the registered access-start outputs.

Requests use a valid/ready handshake. During an inserted idle cycle, ready is low. On the following cycle the request is accepted. The wait indication, the wait type and the configuration-load strobe are registered, so they appear in the cycle after the idle decision. The access-start pulse appears in the cycle after acceptance.

Top module: `ebus_wait_sequencer`

## Requirements
- R1: After reset the wait, load and start outputs are low, ready is high when idle, no previous chip select is held, and the pending-reload flag is clear. The first access after reset is accepted in its first cycle with no idle cycle.
- R2: A configuration write with `cfg_sel` = 3 (mode register) raises the pending-reload flag. The next access to the same chip select as the previous access is held for one cycle with `wait_kind` = 2 (reload) and `cfg_load` high.
- R3: Configuration writes with `cfg_sel` = 0, 1 or 2 (setup, pulse, cycle) leave the pending-reload flag unchanged. A following access to the same chip select starts without an idle cycle.
- R4: The reload idle cycle is inserted whichever chip select's mode register was written, including one other than the accessed chip select.
- R5: An access whose chip select differs from that of the previous accepted access gets exactly one idle cycle with `wait_kind` = 1. `cfg_load` is high in it only when a reload was pending. A pending reload is consumed by that cycle, so the next access to the same chip select starts with no idle cycle.
- R6: A read (`req_write` = 0) with `req_rd_setup` nonzero gets one idle cycle with `wait_kind` = 3 when the previous accepted access was a write with `req_wstrobe_ctl` = 1 and `req_wr_hold` = 0. No idle cycle is inserted for a zero read setup, for a nonzero write hold, or for a write not controlled by the write strobe.
- R7: When several conditions hold, only one idle cycle is inserted. Its type is chosen by priority: chip-select change first, then reload, then early read.
- R8: `req_ready` is low during the idle cycle and high in the next cycle, where the request is accepted. `acc_go` pulses for one cycle, one cycle after acceptance, carrying the accepted chip select and direction. `wait_kind` is 0 whenever `wait_ins` is low.
- R9: `cfg_load` is asserted only together with `wait_ins`, and only with the chip-select-change or reload type. The pending flag is cleared in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access request accepted this cycle |
| req_cs | input | CS_W | Target chip select |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wstrobe_ctl | input | 1 | Write is controlled by the write strobe |
| req_wr_hold | input | HOLD_W | Write hold cycles of the target device |
| req_rd_setup | input | SETUP_W | Read setup cycles of the target device |
| cfg_we | input | 1 | Software configuration register write |
| cfg_sel | input | 2 | Register written: 0 setup, 1 pulse, 2 cycle, 3 mode |
| cfg_cs | input | CS_W | Chip select whose register is written |
| wait_ins | output | 1 | Idle cycle was inserted (registered) |
| wait_kind | output | 2 | 0 none, 1 chip-select change, 2 reload, 3 early read |
| cfg_load | output | 1 | Load new configuration set (registered strobe) |
| acc_go | output | 1 | Access start pulse to the bus controller |
| acc_cs | output | CS_W | Chip select of the started access |
| acc_write | output | 1 | Direction of the started access |

## Verification
Access sequences are built to separate each cause of an idle cycle from its near misses.

- **Early read:** it is triggered by a write under write-strobe control with zero hold, followed by a read with nonzero setup. The same pair is then repeated with zero read setup, with a nonzero hold, and with a write not controlled by the strobe. This shows that all three conditions are needed.
- **Reload:** timing-only register writes are contrasted with mode writes aimed at another chip select. This tells whether the pending flag is raised by register kind alone.
- **Overlapping causes:** a chip-select change that coincides with a pending reload, and a reload that coincides with an early-read pair, expose the priority order and show that only one cycle is inserted.
- **Consumption:** the access after each idle cycle shows whether the pending reload was used up.

// File: rtl/ebus_wait_pkg.sv
package ebus_wait_pkg;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_CSCHG  = 2'd1,
    WK_RELOAD = 2'd2,
    WK_EARLY  = 2'd3
  } wait_kind_e;

  typedef enum logic [1:0] {
    CR_SETUP = 2'd0,
    CR_PULSE = 2'd1,
    CR_CYCLE = 2'd2,
    CR_MODE  = 2'd3
  } cfg_reg_e;

endpackage

// File: rtl/ebus_cfg_tracker.sv
module ebus_cfg_tracker
  import ebus_wait_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_we,
  input  cfg_reg_e cfg_sel,
  input  logic     consume,
  output logic     pend
);

  logic set_pend;
  assign set_pend = cfg_we && (cfg_sel == CR_MODE);

  // a new mode write in the consuming cycle wins, so it is not lost
  always_ff @(posedge clk) begin
    if (rst)           pend <= 1'b0;
    else if (set_pend) pend <= 1'b1;
    else if (consume)  pend <= 1'b0;
  end

  AST_TIMING_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!pend && cfg_we && cfg_sel != CR_MODE) |=> !pend); // R3

endmodule

// File: rtl/ebus_access_history.sv
module ebus_access_history #(
  parameter int NUM_CS  = 6,
  parameter int HOLD_W  = 3,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CS_W-1:0]   acc_cs_in,
  input  logic              acc_wr_in,
  input  logic              acc_wstrobe_in,
  input  logic [HOLD_W-1:0] acc_hold_in,
  output logic              prev_valid,
  output logic [CS_W-1:0]   prev_cs,
  output logic              prev_wr_nohold
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid     <= 1'b0;
      prev_cs        <= '0;
      prev_wr_nohold <= 1'b0;
    end else if (accept) begin
      prev_valid     <= 1'b1;
      prev_cs        <= acc_cs_in;
      prev_wr_nohold <= acc_wr_in && acc_wstrobe_in && (acc_hold_in == '0);
    end
  end

  AST_CS_RANGE: assert property (@(posedge clk) disable iff (rst)
    accept |-> (int'(acc_cs_in) < NUM_CS)); // R4

endmodule

// File: rtl/ebus_wait_arbiter.sv
module ebus_wait_arbiter
  import ebus_wait_pkg::*;
#(
  parameter int NUM_CS  = 6,
  parameter int SETUP_W = 6,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               req_valid,
  input  logic [CS_W-1:0]    req_cs,
  input  logic               req_write,
  input  logic [SETUP_W-1:0] req_rd_setup,
  input  logic               prev_valid,
  input  logic [CS_W-1:0]    prev_cs,
  input  logic               prev_wr_nohold,
  input  logic               pend,
  output wait_kind_e         kind
);

  logic need_cs, need_rl, need_er;

  assign need_cs = req_valid && prev_valid && (req_cs != prev_cs);
  assign need_rl = req_valid && pend;
  assign need_er = req_valid && prev_wr_nohold && !req_write && (req_rd_setup != '0);

  always_comb begin
    if (need_cs)      kind = WK_CSCHG;
    else if (need_rl) kind = WK_RELOAD;
    else if (need_er) kind = WK_EARLY;
    else              kind = WK_NONE;
  end

endmodule

// File: rtl/ebus_wait_sequencer.sv
module ebus_wait_sequencer
  import ebus_wait_pkg::*;
#(
  parameter int NUM_CS  = 6,
  parameter int HOLD_W  = 3,
  parameter int SETUP_W = 6,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CS_W-1:0]    req_cs,
  input  logic               req_write,
  input  logic               req_wstrobe_ctl,
  input  logic [HOLD_W-1:0]  req_wr_hold,
  input  logic [SETUP_W-1:0] req_rd_setup,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [CS_W-1:0]    cfg_cs,
  output logic               wait_ins,
  output logic [1:0]         wait_kind,
  output logic               cfg_load,
  output logic               acc_go,
  output logic [CS_W-1:0]    acc_cs,
  output logic               acc_write
);

  logic            pend, consume, waited_q, issue_wait, accept;
  logic            prev_valid, prev_wr_nohold;
  logic [CS_W-1:0] prev_cs;
  wait_kind_e      kind, kind_q;

  ebus_cfg_tracker u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_reg_e'(cfg_sel)),
    .consume (consume),
    .pend    (pend)
  );

  ebus_access_history #(.NUM_CS(NUM_CS), .HOLD_W(HOLD_W)) u_hist (
    .clk            (clk),
    .rst            (rst),
    .accept         (accept),
    .acc_cs_in      (req_cs),
    .acc_wr_in      (req_write),
    .acc_wstrobe_in (req_wstrobe_ctl),
    .acc_hold_in    (req_wr_hold),
    .prev_valid     (prev_valid),
    .prev_cs        (prev_cs),
    .prev_wr_nohold (prev_wr_nohold)
  );

  ebus_wait_arbiter #(.NUM_CS(NUM_CS), .SETUP_W(SETUP_W)) u_arb (
    .req_valid      (req_valid),
    .req_cs         (req_cs),
    .req_write      (req_write),
    .req_rd_setup   (req_rd_setup),
    .prev_valid     (prev_valid),
    .prev_cs        (prev_cs),
    .prev_wr_nohold (prev_wr_nohold),
    .pend           (pend),
    .kind           (kind)
  );

  // one idle cycle per request: the flag masks the arbiter until acceptance
  assign issue_wait = (kind != WK_NONE) && !waited_q;
  assign req_ready  = !issue_wait;
  assign accept     = req_valid && req_ready;
  assign consume    = issue_wait && pend && (kind == WK_CSCHG || kind == WK_RELOAD);

  always_ff @(posedge clk) begin
    if (rst)             waited_q <= 1'b0;
    else if (accept)     waited_q <= 1'b0;
    else if (issue_wait) waited_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_ins  <= 1'b0;
      kind_q    <= WK_NONE;
      cfg_load  <= 1'b0;
      acc_go    <= 1'b0;
      acc_cs    <= '0;
      acc_write <= 1'b0;
    end else begin
      wait_ins <= issue_wait;
      kind_q   <= issue_wait ? kind : WK_NONE;
      cfg_load <= consume;
      acc_go   <= accept;
      if (accept) begin
        acc_cs    <= req_cs;
        acc_write <= req_write;
      end
    end
  end

  assign wait_kind = kind_q;

  AST_SINGLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    wait_ins |=> !wait_ins); // R7
  AST_KIND_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wait_ins |-> (wait_kind == WK_NONE)); // R8
  AST_GO_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    acc_go |-> $past(req_ready)); // R8
  AST_LOAD_WITH_WAIT: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> (wait_ins && (wait_kind == WK_CSCHG || wait_kind == WK_RELOAD))); // R9
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pend && !waited_q) |-> !req_ready); // R2
  AST_CFG_CS_RANGE: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> (int'(cfg_cs) < NUM_CS)); // R4

endmodule

// File: tb/ebus_wait_sequencer_test.sv
module ebus_wait_sequencer_test;

  localparam int NUM_CS = 6;
  localparam int CS_W   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_wstrobe_ctl = 1'b0;
  logic [CS_W-1:0] req_cs = '0, cfg_cs = '0;
  logic [2:0] req_wr_hold = '0;
  logic [5:0] req_rd_setup = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic       req_ready, wait_ins, cfg_load, acc_go, acc_write;
  logic [1:0] wait_kind;
  logic [CS_W-1:0] acc_cs;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ebus_wait_sequencer #(.NUM_CS(NUM_CS), .HOLD_W(3), .SETUP_W(6)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_write(req_write), .req_wstrobe_ctl(req_wstrobe_ctl),
    .req_wr_hold(req_wr_hold), .req_rd_setup(req_rd_setup),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_cs(cfg_cs),
    .wait_ins(wait_ins), .wait_kind(wait_kind), .cfg_load(cfg_load),
    .acc_go(acc_go), .acc_cs(acc_cs), .acc_write(acc_write)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int cs);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_cs = CS_W'(cs);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access; exp_kind 0 means no idle cycle expected
  task automatic access(input string req, input int cs, input bit wr, input bit ws,
                        input int hold, input int setup, input int exp_kind, input bit exp_load);
    @(negedge clk);
    req_valid = 1'b1; req_cs = CS_W'(cs); req_write = wr; req_wstrobe_ctl = ws;
    req_wr_hold = 3'(hold); req_rd_setup = 6'(setup);
    #1;
    check(req, "ready in first cycle", int'(req_ready), (exp_kind == 0) ? 1 : 0);
    if (exp_kind != 0) begin
      @(negedge clk);
      check(req, "wait_ins", int'(wait_ins), 1);
      check(req, "wait_kind", int'(wait_kind), exp_kind);
      check(req, "cfg_load", int'(cfg_load), int'(exp_load));
      check(req, "ready after idle", int'(req_ready), 1);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "no wait after accept", int'(wait_ins), 0);
    check(req, "acc_go", int'(acc_go), 1);
    check(req, "acc_cs", int'(acc_cs), cs);
    check(req, "acc_write", int'(acc_write), int'(wr));
    @(negedge clk);
    check(req, "acc_go single pulse", int'(acc_go), 0);
  endtask

  task automatic t_reset();
    check("R1", "wait_ins", int'(wait_ins), 0);
    check("R1", "cfg_load", int'(cfg_load), 0);
    check("R1", "acc_go", int'(acc_go), 0);
    check("R1", "idle ready", int'(req_ready), 1);
    access("R1", 2, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_early_read();
    access("R6", 2, 0, 0, 0, 0, 0, 0);
    access("R6", 2, 1, 1, 0, 0, 0, 0);
    access("R6", 2, 0, 0, 0, 2, 3, 0);
    access("R6", 2, 1, 1, 0, 0, 0, 0);
    access("R6", 2, 0, 0, 0, 0, 0, 0);
    access("R6", 2, 1, 1, 1, 0, 0, 0);
    access("R6", 2, 0, 0, 0, 2, 0, 0);
    access("R6", 2, 1, 0, 0, 0, 0, 0);
    access("R6", 2, 0, 0, 0, 2, 0, 0);
  endtask

  task automatic t_timing_only();
    cfg_write(0, 2);
    cfg_write(1, 2);
    cfg_write(2, 2);
    access("R3", 2, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reload();
    cfg_write(3, 5);
    access("R4", 2, 0, 0, 0, 0, 2, 1);
    access("R2", 2, 0, 0, 0, 0, 0, 0);
    cfg_write(3, 2);
    access("R2", 2, 1, 0, 0, 0, 2, 1);
  endtask

  task automatic t_cs_change();
    access("R5", 4, 0, 0, 0, 0, 1, 0);
    cfg_write(3, 4);
    access("R5", 1, 0, 0, 0, 0, 1, 1);
    access("R5", 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority();
    access("R7", 1, 1, 1, 0, 0, 0, 0);
    cfg_write(3, 0);
    access("R7", 1, 0, 0, 0, 3, 2, 1);
    access("R7", 1, 1, 1, 0, 0, 0, 0);
    access("R7", 3, 0, 0, 0, 3, 1, 0);
    access("R9", 3, 1, 1, 0, 0, 0, 0);
    cfg_write(3, 3);
    access("R9", 0, 0, 0, 0, 3, 1, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_early_read();
    t_timing_only();
    t_reload();
    t_cs_change();
    t_priority();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule